// File: doc/BRIEF.md
# Polled Factorial Register Unit

This block is a small register file on a 32-bit register bus. It holds a fixed identification word, a scratch register that stores the complement of whatever is written to it, and a factorial engine that runs in the background. Software writes an operand n to the value register. A busy flag in the status register then rises. Software polls that flag until it drops, and then reads n! (modulo 2^32) back from the same value register.

The engine does one multiply per clock cycle. It starts with an accumulator of 1 and multiplies by a down-counter until the counter reaches zero. It also stops as soon as the accumulator becomes zero, since every later product would stay zero. An enable bit in the status register decides whether completion drives a one-cycle cause pulse for a downstream interrupt collector.

Reads are combinational: the read data follows the address and size inputs in the same cycle. Writes take effect at the rising clock edge on which the write strobe is sampled.

Top module: `fact_unit`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise complement of the written data, and a 4-byte read of 0x04 returns the stored word.
- R3: A 4-byte write to offset 0x08 while idle loads the operand and sets busy, which is status bit 0 at offset 0x20. While busy is set, reading 0x08 returns the operand as loaded.
- R4: A write to 0x08 while busy is ignored. Neither the operand shown nor the final result changes.
- R5: On completion, offset 0x08 holds n·(n−1)·…·1 in 32-bit wraparound arithmetic and busy clears. Operands 0 and 1 both give 1.
- R6: For an operand n of at most 33, busy stays set for exactly n+1 clock cycles after the loading edge.
- R7: When the accumulator becomes zero, the computation finishes on the next cycle with result 0. Operand 0xFFFFFFFF finishes within 64 cycles.
- R8: Status bit 7 at offset 0x20 is the completion-cause enable and can be read and written. Writes to every other status bit, including busy, have no effect.
- R9: `done_cause` pulses high for exactly one cycle per completion when the enable is set, and never when it is clear. Busy is low in the cycle after the pulse.
- R10: Accesses whose size is not 4 bytes are ignored on write and read back as 0xFFFFFFFF.
- R11: Reads of unmapped offsets (for example 0x0C and 0x80) return 0xFFFFFFFF. Writes to them change no register.
- R12: After reset, scratch, value and status all read 0, and `done_cause` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (20) | Byte offset of the access |
| bus_size | input | SIZE_W (4) | Access size in bytes; only 4 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr/bus_size |
| done_cause | output | 1 | One-cycle completion pulse, gated by the status enable |

## Verification
The assertions take for granted that `bus_addr` and `bus_size` are steady, known values whenever a read is being judged. They also assume that no write is issued in the same cycle as reset. The stimulus meets these conditions: it changes inputs only at the falling edge, returns the size to 4 after each odd-sized access, and starts every transaction after reset has been released. Busy-window lengths are measured by polling status once per cycle, starting from the first falling edge after the loading edge.

// File: rtl/fact_pkg.sv
`timescale 1ns/1ps
package fact_pkg;
    localparam int WORD_W    = 32;
    localparam int ACC_BYTES = 4;

    localparam logic [31:0] OFS_ID        = 32'h0000_0000;
    localparam logic [31:0] OFS_SCRATCH   = 32'h0000_0004;
    localparam logic [31:0] OFS_VALUE     = 32'h0000_0008;
    localparam logic [31:0] OFS_STATUS    = 32'h0000_0020;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_EN_BIT   = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_ID,
        SEL_SCRATCH,
        SEL_VALUE,
        SEL_STATUS,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic size_ok;
    } access_t;

    typedef struct packed {
        logic  busy;
        word_t acc;
        word_t cnt;
    } eng_state_t;

    function automatic sel_e decode_offset(input logic [31:0] ofs);
        case (ofs)
            OFS_ID:      return SEL_ID;
            OFS_SCRATCH: return SEL_SCRATCH;
            OFS_VALUE:   return SEL_VALUE;
            OFS_STATUS:  return SEL_STATUS;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic word_t status_word(input logic busy, input logic en);
        word_t w;
        w = '0;
        w[STAT_BUSY_BIT] = busy;
        w[STAT_EN_BIT]   = en;
        return w;
    endfunction
endpackage

// File: rtl/fact_access.sv
`timescale 1ns/1ps
module fact_access
    import fact_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output access_t           acc
);
    localparam logic [SIZE_W-1:0] GOOD_SIZE = SIZE_W'(ACC_BYTES);

    logic [31:0] ofs;

    always_comb begin
        ofs         = 32'(addr);
        acc.sel     = decode_offset(ofs);
        acc.size_ok = (size == GOOD_SIZE);
    end
endmodule

// File: rtl/fact_engine.sv
`timescale 1ns/1ps
module fact_engine
    import fact_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t operand,
    output logic  busy,
    output logic  done,
    output word_t result
);
    eng_state_t st;
    logic       finish;

    // Stop when the counter is exhausted or the product has collapsed to zero.
    assign finish = (st.cnt == '0) || (st.acc == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.busy <= 1'b1;
            st.acc  <= word_t'(1);
            st.cnt  <= operand;
        end else if (st.busy) begin
            if (finish) begin
                st.busy <= 1'b0;
            end else begin
                st.acc <= st.acc * st.cnt;
                st.cnt <= st.cnt - word_t'(1);
            end
        end
    end

    assign busy   = st.busy;
    assign done   = st.busy && finish;
    assign result = st.acc;
endmodule

// File: rtl/fact_regs.sv
`timescale 1ns/1ps
module fact_regs
    import fact_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0100_00ED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  sel_e  sel,
    input  word_t wdata,
    input  logic  eng_busy,
    input  logic  eng_done,
    input  word_t eng_result,
    output logic  start,
    output word_t operand,
    output word_t rd_word,
    output logic  irq_en,
    output logic  done_cause
);
    word_t scratch_q;
    word_t value_q;
    logic  en_q;

    assign start   = wr_en && (sel == SEL_VALUE) && !eng_busy;
    assign operand = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            value_q   <= '0;
            en_q      <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_SCRATCH)
                scratch_q <= ~wdata;
            if (wr_en && sel == SEL_STATUS)
                en_q <= wdata[STAT_EN_BIT];
            if (start)
                value_q <= wdata;
            else if (eng_done)
                value_q <= eng_result;
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:      rd_word = ID_VALUE;
            SEL_SCRATCH: rd_word = scratch_q;
            SEL_VALUE:   rd_word = value_q;
            SEL_STATUS:  rd_word = status_word(eng_busy, en_q);
            default:     rd_word = '1;
        endcase
    end

    assign irq_en     = en_q;
    assign done_cause = eng_done && en_q;
endmodule

// File: rtl/fact_unit.sv
`timescale 1ns/1ps
module fact_unit
    import fact_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          SIZE_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h0100_00ED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              done_cause
);
    access_t acc;
    logic    wr_en;
    logic    start;
    word_t   operand;
    word_t   rd_word;
    word_t   eng_result;
    logic    eng_busy;
    logic    eng_done;
    logic    irq_en;

    fact_access #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_access (
        .addr (bus_addr),
        .size (bus_size),
        .acc  (acc)
    );

    assign wr_en = bus_wr && acc.size_ok;

    fact_regs #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .sel        (acc.sel),
        .wdata      (bus_wdata),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .start      (start),
        .operand    (operand),
        .rd_word    (rd_word),
        .irq_en     (irq_en),
        .done_cause (done_cause)
    );

    fact_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .busy    (eng_busy),
        .done    (eng_done),
        .result  (eng_result)
    );

    assign bus_rdata = acc.size_ok ? rd_word : '1;
endmodule

// File: rtl/fact_unit_chk.sv
`timescale 1ns/1ps
module fact_unit_chk #(
    parameter int          ADDR_W   = 20,
    parameter int          SIZE_W   = 4,
    parameter logic [31:0] ID_VALUE = 32'h0100_00ED
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SIZE_W-1:0] bus_size,
    input logic [31:0]       bus_rdata,
    input logic              done_cause,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              irq_en
);
    localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(32'h00);
    localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(32'h08);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(32'h20);
    localparam logic [SIZE_W-1:0] S_WORD   = SIZE_W'(4);

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_ID && bus_size == S_WORD) |-> bus_rdata == ID_VALUE); // R1
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_VALUE && bus_size == S_WORD && !eng_busy) |=> eng_busy); // R3
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(eng_busy) |-> $past(eng_done)); // R5
    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_STATUS && bus_size == S_WORD) |-> (bus_rdata[0] == eng_busy && bus_rdata[7] == irq_en)); // R8
    AST_CAUSE_GATED: assert property (@(posedge clk) disable iff (rst)
        done_cause |-> irq_en); // R9
    AST_CAUSE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_cause |=> !eng_busy); // R9
    AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_size != S_WORD) |-> bus_rdata == 32'hFFFF_FFFF); // R10
endmodule

bind fact_unit fact_unit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ID_VALUE(ID_VALUE)) u_chk (.*);

// File: tb/tb_fact_unit.sv
`timescale 1ns/1ps
module tb_fact_unit;
    localparam int ADDR_W = 20;
    localparam int SIZE_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [SIZE_W-1:0] bus_size = SIZE_W'(4);
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              done_cause;

    int n_chk = 0;
    int n_bad = 0;
    int cause_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fact_unit dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_cause(done_cause)
    );

    always @(negedge clk) if (!rst && done_cause) cause_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input int sz = 4);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d; bus_size = SIZE_W'(sz);
        @(posedge clk);
        #2;
        bus_wr = 1'b0; bus_size = SIZE_W'(4);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, input int sz = 4);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_size = SIZE_W'(sz);
        #2;
        d = bus_rdata;
        bus_size = SIZE_W'(4);
    endtask

    function automatic logic [31:0] fact_ref(input int n);
        logic [31:0] p = 32'd1;
        for (int i = n; i > 0; i--) p = p * 32'(i);
        return p;
    endfunction

    task automatic run_fact(input logic [31:0] n, input int limit, output int cycles, output logic [31:0] res);
        logic [31:0] s;
        wr(32'h08, n);
        cycles = 0;
        rd(32'h20, s);
        while (s[0] && cycles < limit) begin
            cycles++;
            rd(32'h20, s);
        end
        rd(32'h08, res);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(32'h04, d); check("R12 scratch", d, 32'h0);
        rd(32'h08, d); check("R12 value", d, 32'h0);
        rd(32'h20, d); check("R12 status", d, 32'h0);
        check("R12 cause", {31'b0, done_cause}, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] d;
        rd(32'h00, d); check("R1 id", d, 32'h0100_00ED);
    endtask

    task automatic t_scratch();
        logic [31:0] d;
        wr(32'h04, 32'h1234_5678); rd(32'h04, d); check("R2 inverse", d, 32'hEDCB_A987);
        wr(32'h04, 32'hFFFF_0000); rd(32'h04, d); check("R2 inverse2", d, 32'h0000_FFFF);
    endtask

    task automatic t_fact(input int n);
        int cyc; logic [31:0] res;
        run_fact(32'(n), 200, cyc, res);
        check($sformatf("R5 result n=%0d", n), res, fact_ref(n));
        check($sformatf("R6 busy cycles n=%0d", n), 32'(cyc), 32'(n + 1));
    endtask

    task automatic t_operand_visible();
        logic [31:0] d;
        wr(32'h08, 32'd7);
        rd(32'h08, d); check("R3 operand while busy", d, 32'd7);
        rd(32'h20, d); check("R3 busy set", {31'b0, d[0]}, 32'd1);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_lock();
        int cyc; logic [31:0] d;
        wr(32'h08, 32'd10);
        wr(32'h08, 32'd3);
        rd(32'h08, d); check("R4 operand kept", d, 32'd10);
        cyc = 0;
        rd(32'h20, d);
        while (d[0] && cyc < 100) begin cyc++; rd(32'h20, d); end
        rd(32'h08, d); check("R4 result kept", d, 32'd3628800);
    endtask

    task automatic t_zero_short();
        int cyc; logic [31:0] res;
        run_fact(32'hFFFF_FFFF, 100, cyc, res);
        check("R7 result zero", res, 32'h0);
        check("R7 within 64", {31'b0, (cyc <= 64)}, 32'd1);
        run_fact(32'd34, 100, cyc, res);
        check("R7 n=34 zero", res, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(32'h20, 32'h0000_00FF); rd(32'h20, d); check("R8 enable set", d, 32'h0000_0080);
        wr(32'h20, 32'h0000_0001); rd(32'h20, d); check("R8 enable clear", d, 32'h0);
    endtask

    task automatic t_cause();
        int cyc; logic [31:0] res;
        wr(32'h20, 32'h80);
        cause_cnt = 0;
        run_fact(32'd3, 50, cyc, res);
        repeat (2) @(negedge clk);
        check("R9 one pulse enabled", 32'(cause_cnt), 32'd1);
        wr(32'h20, 32'h00);
        cause_cnt = 0;
        run_fact(32'd3, 50, cyc, res);
        repeat (2) @(negedge clk);
        check("R9 no pulse disabled", 32'(cause_cnt), 32'd0);
    endtask

    task automatic t_size();
        logic [31:0] d;
        wr(32'h04, 32'h0000_0000);
        wr(32'h04, 32'hAAAA_AAAA, 2);
        rd(32'h04, d); check("R10 narrow write ignored", d, 32'hFFFF_FFFF);
        rd(32'h04, d, 2); check("R10 narrow read ones", d, 32'hFFFF_FFFF);
        rd(32'h00, d, 8); check("R10 wide read ones", d, 32'hFFFF_FFFF);
        wr(32'h08, 32'd4, 1);
        rd(32'h20, d); check("R10 odd size no start", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(32'h0C, d); check("R11 0x0C ones", d, 32'hFFFF_FFFF);
        rd(32'h80, d); check("R11 0x80 ones", d, 32'hFFFF_FFFF);
        wr(32'h24, 32'h0000_0080);
        wr(32'h10, 32'h0000_0000);
        rd(32'h20, d); check("R11 status untouched", d, 32'h0);
        rd(32'h04, d); check("R11 scratch untouched", d, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_id();
        t_scratch();
        t_fact(0);
        t_fact(1);
        t_fact(5);
        t_fact(12);
        t_fact(13);
        t_fact(33);
        t_operand_visible();
        t_lock();
        t_zero_short();
        t_status();
        t_cause();
        t_size();
        t_unmapped();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule